// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller

This block gathers up to 32 level-sensitive interrupt lines and drives two processor request outputs: a normal request and a fast request. Each line has its own 6-bit priority and a class bit. The class bit sends the line to either the normal output or the fast output. A line is pending while its sampled input is high or while software holds its software-interrupt bit. It takes part in arbitration only when it is pending and its mask bit is clear. Among the lines of one class, the line with the numerically lowest priority value wins. When several lines share that value, the line with the highest number wins.

An output rises only while its channel is armed. When it rises, it captures the winning line number into a code register. The output then stays high, and the code stays frozen, until software writes the channel's new-agreement bit. That write lowers the output and arms the channel again. A global mask bit stops both outputs from rising. A soft-reset bit returns the whole block to its reset state.

The block has a simple word-addressed register port: a write strobe, an address, write data, and combinational read data. Reads have no side effects.

Top module: `lvl_intc`

## Requirements
- R1: After reset the mask register reads all ones, every per-line register reads 0, both winner codes read 0, both outputs are low, offset 0x000 reads 0x21 and offset 0x014 reads 1.
- R2: A line is pending while its input, sampled one clock earlier, is high or its software bit is set. Writing 0x090 ORs the written ones into the software bits, and reading 0x090 returns them. Writing 0x094 clears the software bits written as one. Offset 0x080 reads the sampled inputs.
- R3: Offset 0x098 reads pending AND NOT mask AND NOT class. Offset 0x09C reads pending AND NOT mask AND class.
- R4: Writing 0x084 replaces the mask. Writing 0x088 clears the mask bits written as one. Writing 0x08C sets the mask bits written as one. Offsets 0x088 and 0x08C read 0. A line whose mask bit is set never drives an output.
- R5: The per-line register of line n is at 0x100+4n. Bits [7:2] hold its priority and bit 0 holds its class (1 = fast output). It reads back with every other bit zero.
- R6: The winner is the unmasked pending line of the class with the lowest priority value. On a tie the highest line number wins. The winner's number is captured when the output rises and reads at 0x040 (normal) or 0x044 (fast).
- R7: An armed output rises on the clock edge after an unmasked pending line of its class is seen. It then stays high, with its code unchanged, until a write to 0x048 with bit 0 (normal) or bit 1 (fast) set. That write lowers the output on the same edge and re-arms the channel.
- R8: Bit 2 of 0x048 is the global mask and reads back at bit 2. While it is set, neither output rises. Every write to 0x048 reloads bit 2.
- R9: Bit 0 of 0x010 is stored and read back. Writing bit 1 of 0x010 returns every register, the outputs and the winner codes to their R1 values on that edge, and bit 1 is not stored.
- R10: Offset 0x050 stores two read/write bits. Offset 0x04C always reads 0. Writes to 0x04C and to the read-only offsets (0x000, 0x014, 0x040, 0x044, 0x080, 0x098, 0x09C) change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NLINES | Level-sensitive interrupt lines |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A wrong winner stays visible at the code registers for as long as the output is held. The bench therefore reads the code one cycle after each rise and compares it with the line it alone made the lowest-priority or only one. A missed re-arm or a stuck mask shows up as an output that stays low two cycles after an unmasked line goes high. A stuck output shows up one cycle after the acknowledge. State that soft reset fails to clear, or that a read-only write disturbs, shows up at the very next read of that register.

// File: rtl/lvl_intc_pkg.sv
// Package: register offsets and channel numbering shared by the controller.
// Assumes a 32-bit register port with word-aligned byte addresses.
package lvl_intc_pkg;
    localparam int OFS_REV      = 'h000;
    localparam int OFS_SYSCFG   = 'h010;
    localparam int OFS_SYSSTAT  = 'h014;
    localparam int OFS_CODE_N   = 'h040;
    localparam int OFS_CODE_F   = 'h044;
    localparam int OFS_CTRL     = 'h048;
    localparam int OFS_PROT     = 'h04C;
    localparam int OFS_IDLE     = 'h050;
    localparam int OFS_RAW      = 'h080;
    localparam int OFS_MASK     = 'h084;
    localparam int OFS_MASK_CLR = 'h088;
    localparam int OFS_MASK_SET = 'h08C;
    localparam int OFS_SW_SET   = 'h090;
    localparam int OFS_SW_CLR   = 'h094;
    localparam int OFS_PEND_N   = 'h098;
    localparam int OFS_PEND_F   = 'h09C;
    localparam int OFS_LINE0    = 'h100;

    localparam int REV_VALUE    = 'h21;

    // Control register bit positions
    localparam int CTL_ACK_N  = 0;
    localparam int CTL_ACK_F  = 1;
    localparam int CTL_GMASK  = 2;
    // Sysconfig bit positions
    localparam int SYS_AUTOIDLE = 0;
    localparam int SYS_SOFTRST  = 1;

    localparam int NCHAN = 2;
    typedef enum logic {
        CH_NORM = 1'b0,
        CH_FAST = 1'b1
    } chan_e;
endpackage

// File: rtl/lvl_intc_regs.sv
// Module: register file and read mux of the controller.
// Holds sampled inputs, software bits, mask, per-line priority/class,
// global mask, idle and autoidle bits. Produces pending vector,
// acknowledge pulses and the soft-reset pulse. Reads are side-effect free.
// Assumes NLINES <= DATA_W and PRIO_W + 2 <= DATA_W.
module lvl_intc_regs
    import lvl_intc_pkg::*;
#(
    parameter int NLINES = 32,
    parameter int PRIO_W = 6,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int CODE_W = $clog2(NLINES)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NLINES-1:0]               irq_in,
    input  logic                            bus_wr,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic [DATA_W-1:0]               bus_wdata,
    input  logic [NCHAN-1:0][CODE_W-1:0]    code_ch,
    output logic [DATA_W-1:0]               bus_rdata,
    output logic [NLINES-1:0]               pend,
    output logic [NLINES-1:0]               mask,
    output logic [NLINES-1:0]               fast_sel,
    output logic [NLINES-1:0][PRIO_W-1:0]   prio,
    output logic                            gmask,
    output logic [NCHAN-1:0]                ack,
    output logic                            soft_rst
);
    localparam int IDX_W = ADDR_W - 2;

    logic [NLINES-1:0]             raw_q, sw_q, mask_q, fast_q;
    logic [NLINES-1:0][PRIO_W-1:0] prio_q;
    logic                          gmask_q, autoidle_q;
    logic [1:0]                    idle_q;
    logic [NLINES-1:0]             wv;
    logic [ADDR_W-1:0]             line_off;
    logic                          line_hit;
    logic [CODE_W-1:0]             line_idx;
    logic                          wr_ctrl, wr_sys;

    assign wv       = bus_wdata[NLINES-1:0];
    assign line_off = bus_addr - ADDR_W'(OFS_LINE0);
    assign line_hit = (bus_addr >= ADDR_W'(OFS_LINE0)) && (bus_addr[1:0] == 2'b00)
                      && (line_off[ADDR_W-1:2] < IDX_W'(NLINES));
    assign line_idx = line_off[CODE_W+1:2];
    assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_sys   = bus_wr && (bus_addr == ADDR_W'(OFS_SYSCFG));
    assign soft_rst = wr_sys && bus_wdata[SYS_SOFTRST];

    // Acknowledge pulses: one per channel, from the control register write
    assign ack[CH_NORM] = wr_ctrl && bus_wdata[CTL_ACK_N];
    assign ack[CH_FAST] = wr_ctrl && bus_wdata[CTL_ACK_F];

    // Sample the interrupt lines once per clock
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) raw_q <= '0;
        else                    raw_q <= irq_in;
    end

    // Software interrupt bits: set and clear aliases
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            sw_q <= '0;
        end else if (bus_wr && bus_addr == ADDR_W'(OFS_SW_SET)) begin
            sw_q <= sw_q | wv;
        end else if (bus_wr && bus_addr == ADDR_W'(OFS_SW_CLR)) begin
            sw_q <= sw_q & ~wv;
        end
    end

    // Mask register with replace, clear and set aliases
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            mask_q <= '1;
        end else if (bus_wr) begin
            case (bus_addr)
                ADDR_W'(OFS_MASK):     mask_q <= wv;
                ADDR_W'(OFS_MASK_CLR): mask_q <= mask_q & ~wv;
                ADDR_W'(OFS_MASK_SET): mask_q <= mask_q | wv;
                default:               mask_q <= mask_q;
            endcase
        end
    end

    // Per-line priority and class registers
    for (genvar i = 0; i < NLINES; i++) begin : g_line
        // Load priority and class of line i on a write to its offset
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst) begin
                prio_q[i] <= '0;
                fast_q[i] <= 1'b0;
            end else if (bus_wr && line_hit && line_idx == CODE_W'(i)) begin
                prio_q[i] <= bus_wdata[PRIO_W+1:2];
                fast_q[i] <= bus_wdata[0];
            end
        end
    end

    // Global mask, reloaded by every control write
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) gmask_q <= 1'b0;
        else if (wr_ctrl)       gmask_q <= bus_wdata[CTL_GMASK];
    end

    // Autoidle flag from the sysconfig register
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) autoidle_q <= 1'b0;
        else if (wr_sys)        autoidle_q <= bus_wdata[SYS_AUTOIDLE];
    end

    // Two stored idle bits
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)                              idle_q <= 2'b00;
        else if (bus_wr && bus_addr == ADDR_W'(OFS_IDLE))    idle_q <= bus_wdata[1:0];
    end

    // Read mux: decode the address into read data, no side effects
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_REV):      bus_rdata = DATA_W'(REV_VALUE);
            ADDR_W'(OFS_SYSCFG):   bus_rdata[SYS_AUTOIDLE] = autoidle_q;
            ADDR_W'(OFS_SYSSTAT):  bus_rdata[0] = 1'b1;
            ADDR_W'(OFS_CODE_N):   bus_rdata[CODE_W-1:0] = code_ch[CH_NORM];
            ADDR_W'(OFS_CODE_F):   bus_rdata[CODE_W-1:0] = code_ch[CH_FAST];
            ADDR_W'(OFS_CTRL):     bus_rdata[CTL_GMASK] = gmask_q;
            ADDR_W'(OFS_PROT):     bus_rdata = '0;
            ADDR_W'(OFS_IDLE):     bus_rdata[1:0] = idle_q;
            ADDR_W'(OFS_RAW):      bus_rdata[NLINES-1:0] = raw_q;
            ADDR_W'(OFS_MASK):     bus_rdata[NLINES-1:0] = mask_q;
            ADDR_W'(OFS_SW_SET):   bus_rdata[NLINES-1:0] = sw_q;
            ADDR_W'(OFS_PEND_N):   bus_rdata[NLINES-1:0] = pend & ~mask_q & ~fast_q;
            ADDR_W'(OFS_PEND_F):   bus_rdata[NLINES-1:0] = pend & ~mask_q & fast_q;
            default: begin
                if (line_hit) begin
                    bus_rdata[PRIO_W+1:2] = prio_q[line_idx];
                    bus_rdata[0]          = fast_q[line_idx];
                end
            end
        endcase
    end

    assign pend     = raw_q | sw_q;
    assign mask     = mask_q;
    assign fast_sel = fast_q;
    assign prio     = prio_q;
    assign gmask    = gmask_q;
endmodule

// File: rtl/lvl_intc_arb.sv
// Module: priority arbiter for one output channel.
// Picks the active line with the lowest priority value; a tie goes to
// the highest line number. Purely combinational.
// Assumes NLINES >= 2.
module lvl_intc_arb #(
    parameter int NLINES = 32,
    parameter int PRIO_W = 6,
    parameter int CODE_W = $clog2(NLINES)
) (
    input  logic [NLINES-1:0]             active,
    input  logic [NLINES-1:0][PRIO_W-1:0] prio,
    output logic                          any,
    output logic [CODE_W-1:0]             win
);
    logic [PRIO_W-1:0] best;

    // Scan upward; "<=" lets a later line take a tie
    always_comb begin
        best = '1;
        win  = '0;
        for (int i = 0; i < NLINES; i++) begin
            if (active[i] && prio[i] <= best) begin
                best = prio[i];
                win  = CODE_W'(i);
            end
        end
    end

    assign any = |active;
endmodule

// File: rtl/lvl_intc_agree.sv
// Module: output handshake for one channel.
// While armed, raises the output on the edge after an active line is seen
// (unless globally masked) and captures the winner code; an acknowledge
// lowers the output and re-arms. Assumes ack and soft_rst are one-cycle pulses.
module lvl_intc_agree #(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              ack,
    input  logic              any,
    input  logic [CODE_W-1:0] win,
    input  logic              gmask,
    output logic              req_o,
    output logic [CODE_W-1:0] code_o
);
    logic armed_q;

    // Arm / fire / acknowledge sequencing
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            armed_q <= 1'b1;
            req_o   <= 1'b0;
            code_o  <= '0;
        end else if (ack) begin
            armed_q <= 1'b1;
            req_o   <= 1'b0;
        end else if (armed_q && any && !gmask) begin
            armed_q <= 1'b0;
            req_o   <= 1'b1;
            code_o  <= win;
        end
    end
endmodule

// File: rtl/lvl_intc.sv
// Module: top of the level-sensitive interrupt controller.
// Connects the register file, one arbiter and one handshake unit per
// output channel (normal and fast). Assumes a single bank of NLINES lines.
module lvl_intc
    import lvl_intc_pkg::*;
#(
    parameter int NLINES = 32,
    parameter int PRIO_W = 6,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] irq_in,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              fiq_o
);
    localparam int CODE_W = $clog2(NLINES);

    logic [NLINES-1:0]             pend, mask, fast_sel;
    logic [NLINES-1:0][PRIO_W-1:0] prio;
    logic                          gmask, soft_rst;
    logic [NCHAN-1:0]              ack, any_ch, req_ch;
    logic [NCHAN-1:0][CODE_W-1:0]  win_ch, code_ch;
    logic [NCHAN-1:0][NLINES-1:0]  active_ch;

    lvl_intc_regs #(
        .NLINES(NLINES), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W),
        .DATA_W(DATA_W), .CODE_W(CODE_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .code_ch(code_ch), .bus_rdata(bus_rdata),
        .pend(pend), .mask(mask), .fast_sel(fast_sel), .prio(prio),
        .gmask(gmask), .ack(ack), .soft_rst(soft_rst)
    );

    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
        // Lines of this channel's class that are pending and unmasked
        assign active_ch[c] = pend & ~mask & ((c == int'(CH_FAST)) ? fast_sel : ~fast_sel);

        lvl_intc_arb #(.NLINES(NLINES), .PRIO_W(PRIO_W), .CODE_W(CODE_W)) u_arb (
            .active(active_ch[c]), .prio(prio), .any(any_ch[c]), .win(win_ch[c])
        );

        lvl_intc_agree #(.CODE_W(CODE_W)) u_agree (
            .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ack(ack[c]),
            .any(any_ch[c]), .win(win_ch[c]), .gmask(gmask),
            .req_o(req_ch[c]), .code_o(code_ch[c])
        );
    end

    assign irq_o = req_ch[CH_NORM];
    assign fiq_o = req_ch[CH_FAST];
endmodule

// File: rtl/lvl_intc_checker.sv
// Module: protocol checker for the controller, bound to the top.
// Relates the outputs to the arbiter, register-file pulses and stored state.
module lvl_intc_checker #(
    parameter int NLINES = 32,
    parameter int CODE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_o,
    input logic              fiq_o,
    input logic [1:0]        any_ch,
    input logic [1:0]        ack,
    input logic              gmask,
    input logic              soft_rst,
    input logic [NLINES-1:0] mask,
    input logic [CODE_W-1:0] code_n
);
    // R8: global mask keeps a low output low
    assert_gmask_norm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gmask && !irq_o) |=> !irq_o);
    assert_gmask_fast_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gmask && !fiq_o) |=> !fiq_o);
    // R7: a rise needs an active line on the cycle before
    assert_rise_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(any_ch[0]));
    assert_rise_source_fast_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fiq_o) |-> $past(any_ch[1]));
    // R7: acknowledge lowers, otherwise held
    assert_ack_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack[0] |=> !irq_o);
    assert_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack[0] && !soft_rst) |=> irq_o);
    // R6: code frozen while output is held
    assert_code_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack[0] && !soft_rst) |=> $stable(code_n));
    // R9: soft reset restores reset state
    assert_soft_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (mask == '1 && !irq_o && !fiq_o && !gmask));
endmodule

bind lvl_intc lvl_intc_checker #(.NLINES(NLINES), .CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .fiq_o(fiq_o),
    .any_ch(any_ch), .ack(ack), .gmask(gmask), .soft_rst(soft_rst),
    .mask(mask), .code_n(code_ch[0])
);

// File: tb/tb_lvl_intc.sv
// Bench: sweeps every line through the handshake and the arbiter,
// then checks class routing, aliases, software bits, masks and soft reset.
module tb_lvl_intc;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NL-1:0] irq_in = '0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;
    int total = 0;
    int fails = 0;
    logic [31:0] d;

    lvl_intc dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'(a); bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = 12'(a);
        #1 v = bus_rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bus_wr = 1'b0; irq_in = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        rd('h000, d); chk("R1 revision", d, 32'h21);
        rd('h014, d); chk("R1 sysstatus", d, 32'h1);
        rd('h084, d); chk("R1 mask", d, 32'hFFFF_FFFF);
        rd('h114, d); chk("R1 line5 reg", d, 32'h0);
        rd('h040, d); chk("R1 code", d, 32'h0);
        chk("R1 outputs", {30'b0, irq_o, fiq_o}, 32'h0);
        // R4 masked lines drive nothing
        irq_in = '1;
        repeat (3) @(negedge clk);
        chk("R4 all masked", {31'b0, irq_o}, 32'h0);
        irq_in = '0;

        // R7/R6/R3/R2 single-line sweep
        wr('h084, 32'h0);
        for (int i = 0; i < NL; i++) begin
            irq_in = NL'(1) << i;
            repeat (2) @(negedge clk);
            chk($sformatf("R7 rise line %0d", i), {31'b0, irq_o}, 32'h1);
            rd('h040, d); chk($sformatf("R6 code line %0d", i), d, 32'(i));
            rd('h098, d); chk($sformatf("R3 pend view line %0d", i), d, 32'h1 << i);
            rd('h080, d); chk($sformatf("R2 raw line %0d", i), d, 32'h1 << i);
            irq_in = '0;
            wr('h048, 32'h1);
            chk($sformatf("R7 ack line %0d", i), {31'b0, irq_o}, 32'h0);
        end

        // R6 tie goes to highest line
        irq_in = '1;
        repeat (2) @(negedge clk);
        rd('h040, d); chk("R6 tie", d, 32'd31);
        for (int i = 0; i < NL; i++) wr('h100 + 4*i, 32'(5 << 2));
        for (int k = 0; k < NL; k++) begin
            wr('h100 + 4*k, 32'(3 << 2));
            wr('h048, 32'h1);
            rd('h040, d); chk($sformatf("R6 lowest prio line %0d", k), d, 32'(k));
            chk($sformatf("R7 rearm line %0d", k), {31'b0, irq_o}, 32'h1);
            rd('h100 + 4*k, d); chk($sformatf("R5 readback line %0d", k), d, 32'h0C);
            wr('h100 + 4*k, 32'(5 << 2));
        end

        // Class routing, pending views, mask aliases
        do_reset();
        wr('h084, 32'h0);
        wr('h11C, 32'h1);
        irq_in = (NL'(1) << 7) | (NL'(1) << 3);
        repeat (3) @(negedge clk);
        chk("R7 fast out", {31'b0, fiq_o}, 32'h1);
        chk("R7 normal out", {31'b0, irq_o}, 32'h1);
        rd('h044, d); chk("R6 fast code", d, 32'd7);
        rd('h040, d); chk("R6 normal code", d, 32'd3);
        rd('h098, d); chk("R3 normal view", d, 32'h8);
        rd('h09C, d); chk("R3 fast view", d, 32'h80);
        wr('h08C, 32'h8);
        rd('h084, d); chk("R4 mask set", d, 32'h8);
        rd('h098, d); chk("R4 masked view", d, 32'h0);
        chk("R7 held under mask", {31'b0, irq_o}, 32'h1);
        wr('h088, 32'h8);
        rd('h084, d); chk("R4 mask clear", d, 32'h0);
        rd('h088, d); chk("R4 clr alias reads 0", d, 32'h0);
        rd('h08C, d); chk("R4 set alias reads 0", d, 32'h0);
        wr('h124, 32'hFFFF_FF0E);
        rd('h124, d); chk("R5 field masking", d, 32'h0C);

        // R2 software bits
        do_reset();
        wr('h090, 32'h1_0000);
        rd('h090, d); chk("R2 sw readback", d, 32'h1_0000);
        rd('h080, d); chk("R2 raw unaffected", d, 32'h0);
        wr('h084, 32'h0);
        @(negedge clk);
        chk("R2 sw raises output", {31'b0, irq_o}, 32'h1);
        rd('h040, d); chk("R2 sw code", d, 32'd16);
        wr('h094, 32'h1_0000);
        rd('h098, d); chk("R2 sw cleared pend", d, 32'h0);
        rd('h090, d); chk("R2 sw cleared", d, 32'h0);
        irq_in = NL'(4);
        wr('h090, 32'h4);
        irq_in = '0;
        repeat (2) @(negedge clk);
        rd('h098, d); chk("R2 sw holds after input drop", d, 32'h4);
        wr('h094, 32'h4);
        rd('h098, d); chk("R2 pend after sw clear", d, 32'h0);

        // R8 global mask
        do_reset();
        wr('h084, 32'h0);
        wr('h048, 32'h4);
        irq_in = NL'(1) << 5;
        repeat (3) @(negedge clk);
        chk("R8 blocked", {31'b0, irq_o}, 32'h0);
        rd('h048, d); chk("R8 readback", d, 32'h4);
        wr('h048, 32'h0);
        @(negedge clk);
        chk("R8 released", {31'b0, irq_o}, 32'h1);
        rd('h040, d); chk("R8 code after release", d, 32'd5);

        // R10 and R9
        wr('h090, 32'h3);
        wr('h010, 32'h1);
        rd('h010, d); chk("R9 autoidle", d, 32'h1);
        wr('h050, 32'h7);
        rd('h050, d); chk("R10 idle", d, 32'h3);
        wr('h04C, 32'h1);
        rd('h04C, d); chk("R10 protection", d, 32'h0);
        wr('h000, 32'h0);
        rd('h000, d); chk("R10 revision ro", d, 32'h21);
        wr('h014, 32'h0);
        rd('h014, d); chk("R10 sysstatus ro", d, 32'h1);
        wr('h080, 32'hFFFF);
        rd('h080, d); chk("R10 raw ro", d, 32'h20);
        wr('h040, 32'h0);
        rd('h040, d); chk("R10 code ro", d, 32'd5);
        irq_in = '0;
        wr('h010, 32'h2);
        chk("R9 outputs cleared", {30'b0, irq_o, fiq_o}, 32'h0);
        rd('h084, d); chk("R9 mask", d, 32'hFFFF_FFFF);
        rd('h090, d); chk("R9 sw bits", d, 32'h0);
        rd('h010, d); chk("R9 sysconfig", d, 32'h0);
        rd('h050, d); chk("R9 idle", d, 32'h0);
        rd('h040, d); chk("R9 code", d, 32'h0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule